// File: doc/BRIEF.md
# Quadrant-Parallel RAM Self-Test Controller

This block runs a built-in memory test on an embedded single-port RAM. The address space is cut into four equal quadrants, and the quadrants are held in four banks that share one offset bus. Each test step therefore reads or writes the same offset in all four quadrants at once, so the test takes a quarter of the cycles a word-by-word walk would take. The test is a March C- sequence of six elements: ascending write-0; ascending read-0/write-1; ascending read-1/write-0; descending read-0/write-1; descending read-1/write-0; and a final ascending read-0. A read takes one cycle and its compare (with the write, if any) takes the next. A write-only element spends one cycle per offset.

Software starts a run by strobing a control write with the start bit set. While the run is in progress, `busy` is high. The start bit clears itself when the run ends, and `busy` is how software sees it. Each quadrant has its own comparator. The first miscompare in any quadrant stops the test, raises the fail flag and freezes the offset being tested. Because the offset is shared, the faulty word is one of four aliased addresses: the offset plus 0, Q, 2Q or 3Q, where Q = 2^(ADDR_W-2). With ADDR_W = 15 (32K words), Q is 0x2000. A run that ends with no miscompare raises the pass flag.

The RAM banks are behavioural arrays. A fault-injection input forces bit 0 of one chosen word to a stuck value on every read, and the testbench uses it.

Top module: `quad_bist`

## Requirements
- R1: After reset, `busy`, `bist_pass` and `bist_fail` are 0 and `fail_offset` is 0.
- R2: A control write with `ctl_start`=1 while idle clears `bist_pass`, `bist_fail` and `fail_offset`, and raises `busy` in the next cycle. While `busy` is high, both flags are 0.
- R3: A fault-free run keeps `busy` high for exactly 11·Q cycles (Q = 2^(ADDR_W-2)). When `busy` falls, `bist_pass`=1 and `bist_fail`=0.
- R4: A stuck bit at full address q·Q+o, for any quadrant q in 0..3, gives `bist_fail`=1 and `bist_pass`=0, with `fail_offset`=o.
- R5: The test stops at the first miscompare and `bist_fail` rises in the cycle `busy` falls. A stuck-at-1 bit 0 ends the run after Q+2o+2 busy cycles, because it is caught in the first read-0 element. A stuck-at-0 bit 0 ends the run after 3Q+2o+2 busy cycles, because it is caught in the first read-1 element.
- R6: While idle and not started, `bist_pass`, `bist_fail` and `fail_offset` hold their values.
- R7: A start write while `busy` is high is ignored, and the run length and result are unchanged.
- R8: A control write with `ctl_start`=0 has no effect on the flags, `busy` or `fail_offset`.
- R9: A new run after a failed one, with the fault removed, clears the old result and ends in pass.
- R10: `bist_pass` and `bist_fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Start bit value written with `ctl_wr` |
| flt_en | input | 1 | Enables the stuck-bit fault model |
| flt_addr | input | ADDR_W | Full RAM address of the faulty word |
| flt_val | input | 1 | Stuck value of bit 0 of the faulty word |
| busy | output | 1 | High while a test run is in progress |
| bist_pass | output | 1 | Last run completed with no miscompare |
| bist_fail | output | 1 | Last run stopped on a miscompare |
| fail_offset | output | ADDR_W-2 | Offset in the lowest quadrant at the failing step |

## Verification
The march is run on a clean RAM and then on RAMs with one stuck bit. The stuck word is placed in different quadrants and at the first, middle and last offsets. A stuck-at-1 fault shows that the first read-0 element catches it. A stuck-at-0 fault can only be caught by a read-1 element, so the two run lengths separate the elements and confirm that the test stops at the first miscompare. Putting the same offset in different quadrants shows that the reported offset drops the quadrant bits. Start writes issued mid-run and zero writes issued while idle tell ignored strobes apart from effective ones.

// File: rtl/quad_bist_pkg.sv
// Shared types and helpers for the quadrant-parallel RAM self-test.
// Assumes a six-element March C- sequence; elements are decoded here so
// the sequencer and any checker read the same definition.
package quad_bist_pkg;

    localparam int NQUAD = 4;

    typedef enum logic [2:0] {
        EL_W0    = 3'd0,
        EL_R0W1  = 3'd1,
        EL_R1W0  = 3'd2,
        EL_DR0W1 = 3'd3,
        EL_DR1W0 = 3'd4,
        EL_R0    = 3'd5
    } march_el_t;

    // Element performs a read-and-compare step
    function automatic logic el_reads(input march_el_t e);
        return (e != EL_W0);
    endfunction

    // Element performs a write step
    function automatic logic el_writes(input march_el_t e);
        return (e != EL_R0);
    endfunction

    // Element walks the offsets from the top down
    function automatic logic el_down(input march_el_t e);
        return (e == EL_DR0W1) || (e == EL_DR1W0);
    endfunction

    // Value every bit is expected to hold when read
    function automatic logic el_rd_val(input march_el_t e);
        return (e == EL_R1W0) || (e == EL_DR1W0);
    endfunction

    // Value written to every bit
    function automatic logic el_wr_val(input march_el_t e);
        return (e == EL_R0W1) || (e == EL_DR0W1);
    endfunction

    // Element that follows e in the march
    function automatic march_el_t el_next(input march_el_t e);
        case (e)
            EL_W0:    return EL_R0W1;
            EL_R0W1:  return EL_R1W0;
            EL_R1W0:  return EL_DR0W1;
            EL_DR0W1: return EL_DR1W0;
            default:  return EL_R0;
        endcase
    endfunction

endpackage

// File: rtl/quad_bist_bank.sv
// One quadrant of the RAM: a behavioural single-port array with a
// registered read port (data valid the cycle after a read enable).
// Assumes reads and writes never coincide. A stuck-bit model forces
// bit 0 of one word on read when flt_hit is set for this bank.
module quad_bist_bank #(
    parameter int OFF_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flt_hit,
    input  logic [OFF_W-1:0]  flt_off,
    input  logic              flt_val,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << OFF_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;
    logic [OFF_W-1:0]  rd_off_q;

    // Array write and registered read
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[off] <= wdata;
            end else begin
                rdata_q  <= mem[off];
                rd_off_q <= off;
            end
        end
    end

    // Apply the stuck-bit fault to the word just read
    always_comb begin
        rdata = rdata_q;
        if (flt_hit && (rd_off_q == flt_off)) begin
            rdata[0] = flt_val;
        end
    end
endmodule

// File: rtl/quad_bist_cmp.sv
// Per-quadrant comparator: flags a miscompare when a compare is enabled
// and the read word differs from the expected all-zeros / all-ones word.
module quad_bist_cmp #(
    parameter int DATA_W = 16
) (
    input  logic              cmp_en,
    input  logic              exp_bit,
    input  logic [DATA_W-1:0] rdata,
    output logic              miss
);
    // Compare against the replicated expected bit
    always_comb begin
        miss = cmp_en && (rdata != {DATA_W{exp_bit}});
    end
endmodule

// File: rtl/quad_bist_seq.sv
// March sequencer: walks the six March C- elements over one shared offset,
// drives the bank strobes, and latches the pass/fail result and the failing
// offset. Assumes one-cycle read latency: a read is issued in phase 0 and
// compared (and written back) in phase 1. Stops at the first miscompare.
module quad_bist_seq
    import quad_bist_pkg::*;
#(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             miss_any,
    output logic             busy,
    output logic             pass,
    output logic             fail,
    output logic [OFF_W-1:0] fail_off,
    output logic             mem_en,
    output logic             mem_we,
    output logic [OFF_W-1:0] mem_off,
    output logic             wr_bit,
    output logic             exp_bit,
    output logic             cmp_en
);
    localparam logic [OFF_W-1:0] OFF_MAX = {OFF_W{1'b1}};

    logic             run_q;
    logic             phase_q;
    march_el_t        el_q;
    logic [OFF_W-1:0] off_q;
    logic             pass_q;
    logic             fail_q;
    logic [OFF_W-1:0] foff_q;

    logic step_done;
    logic at_last;
    logic rd_cyc;
    logic wr_cyc;

    // Decode the current step into strobes and sequencing conditions
    always_comb begin
        step_done = !el_reads(el_q) || phase_q;
        at_last   = el_down(el_q) ? (off_q == '0) : (off_q == OFF_MAX);
        rd_cyc    = run_q && el_reads(el_q) && !phase_q;
        wr_cyc    = run_q && el_writes(el_q) && step_done;
        mem_en    = rd_cyc || wr_cyc;
        mem_we    = wr_cyc;
        mem_off   = off_q;
        wr_bit    = el_wr_val(el_q);
        exp_bit   = el_rd_val(el_q);
        cmp_en    = run_q && el_reads(el_q) && phase_q;
    end

    // Sequence state, result flags and failure offset capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            phase_q <= 1'b0;
            el_q    <= EL_W0;
            off_q   <= '0;
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
            foff_q  <= '0;
        end else if (!run_q) begin
            if (go) begin
                run_q   <= 1'b1;
                phase_q <= 1'b0;
                el_q    <= EL_W0;
                off_q   <= '0;
                pass_q  <= 1'b0;
                fail_q  <= 1'b0;
                foff_q  <= '0;
            end
        end else if (cmp_en && miss_any) begin
            run_q  <= 1'b0;
            fail_q <= 1'b1;
            foff_q <= off_q;
        end else if (step_done) begin
            phase_q <= 1'b0;
            if (at_last) begin
                if (el_q == EL_R0) begin
                    run_q  <= 1'b0;
                    pass_q <= 1'b1;
                end else begin
                    el_q  <= el_next(el_q);
                    off_q <= el_down(el_next(el_q)) ? OFF_MAX : '0;
                end
            end else begin
                off_q <= el_down(el_q) ? (off_q - 1'b1) : (off_q + 1'b1);
            end
        end else begin
            phase_q <= 1'b1;
        end
    end

    assign busy     = run_q;
    assign pass     = pass_q;
    assign fail     = fail_q;
    assign fail_off = foff_q;
endmodule

// File: rtl/quad_bist.sv
// Top of the quadrant-parallel RAM self-test. Holds four RAM banks, one
// comparator per bank and the march sequencer. A start write while idle
// launches a run; fail is the OR of the four comparators, captured by the
// sequencer. Assumes ADDR_W >= 3; quadrant = top two address bits.
module quad_bist
    import quad_bist_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_start,
    input  logic              flt_en,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic              flt_val,
    output logic              busy,
    output logic              bist_pass,
    output logic              bist_fail,
    output logic [ADDR_W-3:0] fail_offset
);
    localparam int OFF_W = ADDR_W - 2;

    logic             go;
    logic             mem_en;
    logic             mem_we;
    logic [OFF_W-1:0] mem_off;
    logic             wr_bit;
    logic             exp_bit;
    logic             cmp_en;
    logic [NQUAD-1:0] miss;
    logic             miss_any;

    // Start request decoded from the control write strobe
    always_comb begin
        go       = ctl_wr && ctl_start;
        miss_any = |miss;
    end

    quad_bist_seq #(.OFF_W(OFF_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .miss_any (miss_any),
        .busy     (busy),
        .pass     (bist_pass),
        .fail     (bist_fail),
        .fail_off (fail_offset),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .mem_off  (mem_off),
        .wr_bit   (wr_bit),
        .exp_bit  (exp_bit),
        .cmp_en   (cmp_en)
    );

    for (genvar q = 0; q < NQUAD; q++) begin : g_quad
        logic [DATA_W-1:0] rdata;
        logic              hit;

        // Fault lands in this quadrant when the top address bits match
        always_comb begin
            hit = flt_en && (flt_addr[ADDR_W-1:OFF_W] == 2'(q));
        end

        quad_bist_bank #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .en      (mem_en),
            .we      (mem_we),
            .off     (mem_off),
            .wdata   ({DATA_W{wr_bit}}),
            .flt_hit (hit),
            .flt_off (flt_addr[OFF_W-1:0]),
            .flt_val (flt_val),
            .rdata   (rdata)
        );

        quad_bist_cmp #(.DATA_W(DATA_W)) u_cmp (
            .cmp_en  (cmp_en),
            .exp_bit (exp_bit),
            .rdata   (rdata),
            .miss    (miss[q])
        );
    end
endmodule

// File: rtl/quad_bist_chk.sv
// Port-level protocol checker for quad_bist, attached with bind.
module quad_bist_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic              ctl_start,
    input logic              busy,
    input logic              bist_pass,
    input logic              bist_fail,
    input logic [ADDR_W-3:0] fail_offset
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bist_pass && bist_fail)); // R10

    AST_BUSY_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(bist_pass || bist_fail)); // R2

    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctl_wr && ctl_start) |=> busy); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(ctl_wr && ctl_start)) |=>
            ($stable(fail_offset) && $stable(bist_pass) && $stable(bist_fail))); // R6

    AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bist_fail) |-> !busy); // R5

    AST_PASS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bist_pass) |-> $fell(busy)); // R3
endmodule

bind quad_bist quad_bist_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_start   (ctl_start),
    .busy        (busy),
    .bist_pass   (bist_pass),
    .bist_fail   (bist_fail),
    .fail_offset (fail_offset)
);

// File: tb/quad_bist_bench.sv
// Directed bench for quad_bist: one task per scenario, each checks itself.
module quad_bist_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int DATA_W     = 16;
    localparam int Q          = 1 << (ADDR_W - 2);
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ctl_wr;
    logic              ctl_start;
    logic              flt_en;
    logic [ADDR_W-1:0] flt_addr;
    logic              flt_val;
    logic              busy;
    logic              bist_pass;
    logic              bist_fail;
    logic [ADDR_W-3:0] fail_offset;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    quad_bist #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_quad_bist (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_start   (ctl_start),
        .flt_en      (flt_en),
        .flt_addr    (flt_addr),
        .flt_val     (flt_val),
        .busy        (busy),
        .bist_pass   (bist_pass),
        .bist_fail   (bist_fail),
        .fail_offset (fail_offset)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Start a run with one control write; return the number of busy cycles
    task automatic run_test(output int nbusy, input int poke_at);
        nbusy = 0;
        @(negedge clk);
        ctl_wr    = 1'b1;
        ctl_start = 1'b1;
        @(negedge clk);
        ctl_wr    = 1'b0;
        ctl_start = 1'b0;
        while (busy && nbusy < 20000) begin
            nbusy++;
            if (nbusy == poke_at) begin
                ctl_wr    = 1'b1;
                ctl_start = 1'b1;
            end else begin
                ctl_wr    = 1'b0;
                ctl_start = 1'b0;
            end
            @(negedge clk);
        end
        ctl_wr    = 1'b0;
        ctl_start = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ctl_wr = 1'b0; ctl_start = 1'b0;
        flt_en = 1'b0; flt_addr = '0; flt_val = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy", busy, 0);
        check("R1", "pass", bist_pass, 0);
        check("R1", "fail", bist_fail, 0);
        check("R1", "offset", fail_offset, 0);
    endtask

    task automatic t_clean();
        int nb;
        flt_en = 1'b0;
        run_test(nb, -1);
        check("R3", "clean busy cycles", nb, 11 * Q);
        check("R3", "clean pass", bist_pass, 1);
        check("R3", "clean fail", bist_fail, 0);
    endtask

    task automatic t_fault(input int quad, input int off, input logic val);
        int nb;
        int exp_nb;
        flt_en   = 1'b1;
        flt_addr = ADDR_W'(quad * Q + off);
        flt_val  = val;
        exp_nb   = val ? (Q + 2 * off + 2) : (3 * Q + 2 * off + 2);
        run_test(nb, -1);
        check("R5", $sformatf("stop cycle q%0d o%0d v%0d", quad, off, val), nb, exp_nb);
        check("R4", "fail flag", bist_fail, 1);
        check("R4", "pass flag", bist_pass, 0);
        check("R4", $sformatf("offset q%0d", quad), fail_offset, off);
    endtask

    task automatic t_hold();
        int off0 = fail_offset;
        repeat (50) @(negedge clk);
        check("R6", "held fail", bist_fail, 1);
        check("R6", "held offset", fail_offset, off0);
        check("R6", "held pass", bist_pass, 0);
    endtask

    task automatic t_rerun();
        flt_en = 1'b0;
        @(negedge clk);
        ctl_wr = 1'b1; ctl_start = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_start = 1'b0;
        check("R2", "busy after start", busy, 1);
        check("R2", "fail cleared", bist_fail, 0);
        check("R2", "offset cleared", fail_offset, 0);
        while (busy) @(negedge clk);
        check("R9", "rerun pass", bist_pass, 1);
        check("R9", "rerun fail", bist_fail, 0);
    endtask

    task automatic t_busy_start();
        int nb;
        flt_en = 1'b0;
        run_test(nb, 100);
        check("R7", "busy cycles with mid-run start", nb, 11 * Q);
        check("R7", "pass after mid-run start", bist_pass, 1);
    endtask

    task automatic t_zero_write();
        @(negedge clk);
        ctl_wr = 1'b1; ctl_start = 1'b0;
        @(negedge clk);
        ctl_wr = 1'b0;
        check("R8", "busy after zero write", busy, 0);
        check("R8", "pass after zero write", bist_pass, 1);
        check("R8", "fail after zero write", bist_fail, 0);
    endtask

    task automatic t_zero_write_fail();
        int off0 = fail_offset;
        @(negedge clk);
        ctl_wr = 1'b1; ctl_start = 1'b0;
        @(negedge clk);
        ctl_wr = 1'b0;
        check("R8", "busy after zero write", busy, 0);
        check("R8", "fail kept", bist_fail, 1);
        check("R8", "offset kept", fail_offset, off0);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
        report();
    end

    initial begin
        t_reset();
        t_clean();
        t_zero_write();
        t_fault(3, 5, 1'b1);
        t_hold();
        t_zero_write_fail();
        t_fault(0, 200, 1'b0);
        t_fault(2, Q - 1, 1'b1);
        t_fault(1, 0, 1'b0);
        t_fault(1, 5, 1'b1);
        t_rerun();
        t_busy_start();
        check("R10", "flags exclusive", int'(bist_pass && bist_fail), 0);
        report();
    end
endmodule